// File: doc/BRIEF.md
# PCI Initiator Address-Phase Sequencer

This block carries a PCI initiator from a local-side request to the end of its address phase. A local engine pulls an active-low request line low for one cycle while presenting a 64-bit address and a 4-bit bus command. The sequencer captures both, asserts the bus request towards the arbiter, and waits. It starts the address phase only when it samples the grant together with an idle bus on the same rising edge.

When built for a 64-bit bus and the captured address has a nonzero upper word, the sequencer emits a dual-address cycle. This is two back-to-back address phases, with the address halves and commands placed on the lower and upper AD/C/BE# lanes as each phase requires. In every other case it emits a single 32-bit address phase. It drives the AD and C/BE# output enables only while it owns an address phase. It pulses a done strobe during the final address-phase cycle, so that a data-phase engine can take over the transaction.

Top module: `pci_addr_seq`

## Requirements
- R1: A low level on `loc_req_n` sampled at a rising edge, while the block is idle, drives `req_n` low from the next cycle. `req_n` then stays low until the address phase begins. The address and command are captured at that same edge.
- R2: `frame_n` goes low only in the cycle after a rising edge at which `gnt_n` was low and both `frame_in_n` and `irdy_in_n` were high. A busy bus (either of those low) delays the start of the address phase.
- R3: If `gnt_n` is high at an edge while the block is requesting, `frame_n` stays high and `req_n` stays low in the next cycle.
- R4: A single address phase lasts exactly one cycle with `frame_n` low. During that cycle `ad_out[31:0]` is the low address word and `cbe_out[3:0]` is the captured command.
- R5: A dual-address cycle is produced only when `BUS64` is 1 and the captured `loc_addr[63:32]` is nonzero. Otherwise the block produces a single phase.
- R6: In the first dual-address phase, `ad_out[31:0]` carries the low word and `ad_out[63:32]` carries the high word. `cbe_out[3:0]` carries the code 4'b1101 and `cbe_out[7:4]` carries the command. `ad_hi_oe` and `cbe_hi_oe` are 1.
- R7: In the second dual-address phase, `frame_n` is still low, `ad_out[31:0]` carries the high word and `cbe_out[3:0]` carries the command. The upper-lane enables are 0. `frame_n` rises after this phase.
- R8: With `BUS64` = 0, `ad_hi_oe` and `cbe_hi_oe` are never 1, and the upper address word is ignored.
- R9: `ad_lo_oe` and `cbe_lo_oe` are 1 exactly during the block's own address-phase cycles and are 0 at all other times.
- R10: While `rst_n` is low, `req_n` and `frame_n` are 1, all four output enables are 0, and `addr_done` is 0.
- R11: `addr_done` is 1 for exactly one cycle, which is the last address-phase cycle of a transaction.
- R12: `req_n` is high throughout every address-phase cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| loc_req_n | input | 1 | Active-low local request to start a transaction |
| loc_addr | input | 64 | Transaction address, captured with the request |
| loc_cmd | input | 4 | Bus command, captured with the request |
| gnt_n | input | 1 | Active-low grant from the arbiter |
| frame_in_n | input | 1 | Sampled FRAME# line of the bus |
| irdy_in_n | input | 1 | Sampled IRDY# line of the bus |
| req_n | output | 1 | Active-low bus request to the arbiter |
| frame_n | output | 1 | Active-low FRAME# drive |
| ad_out | output | 64 | Address lanes drive value |
| ad_lo_oe | output | 1 | Output enable for AD[31:0] |
| ad_hi_oe | output | 1 | Output enable for AD[63:32] |
| cbe_out | output | 8 | Command/byte-enable lanes drive value |
| cbe_lo_oe | output | 1 | Output enable for C/BE#[3:0] |
| cbe_hi_oe | output | 1 | Output enable for C/BE#[7:4] |
| addr_done | output | 1 | One-cycle strobe in the last address-phase cycle |

## Verification
The bench sweeps every command code against several upper-word patterns: zero, a single low bit and a single top bit. It also varies the grant delay, the bus-busy stretch and grant withdrawal, and it runs a 64-bit and a 32-bit instance side by side. A design that ignored the idle condition would raise FRAME# while another master still held FRAME# or IRDY#. A design that treated a withdrawn grant as sticky would start a phase without ownership. A design that chose a dual cycle on a nonzero lower word, or swapped lanes in the second phase, would put the wrong word on AD[31:0] or the wrong code on C/BE#. A 32-bit build that leaked upper-lane enables, or a done strobe issued one phase early, would also be caught.

// File: rtl/pci_addr_seq.sv
module pci_addr_seq #(
  parameter bit BUS64 = 1'b1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        loc_req_n,
  input  logic [63:0] loc_addr,
  input  logic [3:0]  loc_cmd,
  input  logic        gnt_n,
  input  logic        frame_in_n,
  input  logic        irdy_in_n,
  output logic        req_n,
  output logic        frame_n,
  output logic [63:0] ad_out,
  output logic        ad_lo_oe,
  output logic        ad_hi_oe,
  output logic [7:0]  cbe_out,
  output logic        cbe_lo_oe,
  output logic        cbe_hi_oe,
  output logic        addr_done
);
  localparam logic [3:0] DUAL_CMD = 4'b1101;

  typedef enum logic [1:0] {S_IDLE, S_REQ, S_PH1, S_PH2} st_t;
  st_t st;

  logic [31:0] lo_q, hi_q;
  logic [3:0]  cmd_q;
  logic        dual_q;

  wire bus_idle = frame_in_n & irdy_in_n;
  wire in_ph1   = (st == S_PH1);
  wire in_ph2   = (st == S_PH2);
  wire hi_lane  = in_ph1 & dual_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      lo_q   <= '0;
      hi_q   <= '0;
      cmd_q  <= '0;
      dual_q <= 1'b0;
    end else begin
      case (st)
        S_IDLE: if (!loc_req_n) begin
          st     <= S_REQ;
          lo_q   <= loc_addr[31:0];
          hi_q   <= loc_addr[63:32];
          cmd_q  <= loc_cmd;
          dual_q <= BUS64 && (loc_addr[63:32] != 32'd0);
        end
        S_REQ:   if (!gnt_n && bus_idle) st <= S_PH1;
        S_PH1:   st <= dual_q ? S_PH2 : S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  assign req_n     = (st != S_REQ);
  assign frame_n   = ~(in_ph1 | in_ph2);
  assign ad_lo_oe  = in_ph1 | in_ph2;
  assign cbe_lo_oe = in_ph1 | in_ph2;
  assign ad_hi_oe  = hi_lane;
  assign cbe_hi_oe = hi_lane;
  assign addr_done = (in_ph1 & ~dual_q) | in_ph2;

  assign ad_out[31:0]  = in_ph2 ? hi_q : (in_ph1 ? lo_q : 32'd0);
  assign ad_out[63:32] = hi_lane ? hi_q : 32'd0;
  assign cbe_out[3:0]  = hi_lane ? DUAL_CMD : ((in_ph1 | in_ph2) ? cmd_q : 4'd0);
  assign cbe_out[7:4]  = hi_lane ? cmd_q : 4'd0;

  // R2
  start_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(frame_n) |-> $past(!gnt_n && frame_in_n && irdy_in_n));

  // R3
  gnt_loss_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!req_n && gnt_n) |=> (frame_n && !req_n));

  // R12
  req_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_n |-> req_n);

  // R11
  done_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    addr_done |=> (frame_n && !ad_lo_oe && !cbe_lo_oe));

  // R6
  dual_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ad_hi_oe |-> (!frame_n && cbe_hi_oe && cbe_out[3:0] == DUAL_CMD && !addr_done));

  // R7
  dual_second_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ad_hi_oe |=> (!frame_n && addr_done && ad_out[31:0] == $past(ad_out[63:32])
                  && cbe_out[3:0] == $past(cbe_out[7:4])));

  generate
    if (!BUS64) begin : g_narrow
      // R8
      narrow_lanes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(ad_hi_oe || cbe_hi_oe));
    end
  endgenerate
endmodule

// File: tb/pci_addr_seq_tb.sv
module pci_addr_seq_tb;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst_n, loc_req_n, gnt_n, frame_in_n, irdy_in_n;
  logic [63:0] loc_addr;
  logic [3:0]  loc_cmd;
  logic        req_n, frame_n, ad_lo_oe, ad_hi_oe, cbe_lo_oe, cbe_hi_oe, addr_done;
  logic [63:0] ad_out;
  logic [7:0]  cbe_out;
  logic        req_n32, frame_n32, ad_lo_oe32, ad_hi_oe32, cbe_lo_oe32, cbe_hi_oe32, done32;
  logic [63:0] ad_out32;
  logic [7:0]  cbe_out32;

  int checks = 0, errors = 0;
  bit finished = 0;

  pci_addr_seq #(.BUS64(1'b1)) u_dut (
    .clk(clk), .rst_n(rst_n), .loc_req_n(loc_req_n), .loc_addr(loc_addr), .loc_cmd(loc_cmd),
    .gnt_n(gnt_n), .frame_in_n(frame_in_n), .irdy_in_n(irdy_in_n), .req_n(req_n),
    .frame_n(frame_n), .ad_out(ad_out), .ad_lo_oe(ad_lo_oe), .ad_hi_oe(ad_hi_oe),
    .cbe_out(cbe_out), .cbe_lo_oe(cbe_lo_oe), .cbe_hi_oe(cbe_hi_oe), .addr_done(addr_done));

  pci_addr_seq #(.BUS64(1'b0)) u_dut32 (
    .clk(clk), .rst_n(rst_n), .loc_req_n(loc_req_n), .loc_addr(loc_addr), .loc_cmd(loc_cmd),
    .gnt_n(gnt_n), .frame_in_n(frame_in_n), .irdy_in_n(irdy_in_n), .req_n(req_n32),
    .frame_n(frame_n32), .ad_out(ad_out32), .ad_lo_oe(ad_lo_oe32), .ad_hi_oe(ad_hi_oe32),
    .cbe_out(cbe_out32), .cbe_lo_oe(cbe_lo_oe32), .cbe_hi_oe(cbe_hi_oe32), .addr_done(done32));

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic tick();
    @(posedge clk); #2;
  endtask

  task automatic idle_state(input string tag);
    chk({tag, " frame"}, {63'd0, frame_n}, 64'd1);
    chk({tag, " oe"}, {60'd0, ad_lo_oe, ad_hi_oe, cbe_lo_oe, cbe_hi_oe}, 64'd0);
    chk({tag, " done"}, {63'd0, addr_done}, 64'd0);
    chk({tag, " frame32"}, {63'd0, frame_n32}, 64'd1);
    chk({tag, " oe32"}, {60'd0, ad_lo_oe32, ad_hi_oe32, cbe_lo_oe32, cbe_hi_oe32}, 64'd0);
  endtask

  task automatic run(input logic [63:0] addr, input logic [3:0] cmd,
                     input int waitc, input int busy, input bit drop);
    bit dual = (addr[63:32] != 32'd0);
    @(negedge clk);
    loc_req_n = 0; loc_addr = addr; loc_cmd = cmd; gnt_n = 1; frame_in_n = 1; irdy_in_n = 1;
    tick();
    chk("R1 req asserted", {63'd0, req_n}, 64'd0);
    chk("R1 req32 asserted", {63'd0, req_n32}, 64'd0);
    chk("R2 no early frame", {63'd0, frame_n}, 64'd1);
    @(negedge clk);
    loc_req_n = 1; loc_addr = ~addr; loc_cmd = ~cmd;
    for (int w = 0; w < waitc; w++) begin
      tick();
      chk("R1 req held", {63'd0, req_n}, 64'd0);
      chk("R2 frame without grant", {63'd0, frame_n}, 64'd1);
    end
    if (drop) begin
      @(negedge clk); gnt_n = 0; frame_in_n = 0;
      tick();
      chk("R2 frame on busy bus", {63'd0, frame_n}, 64'd1);
      @(negedge clk); gnt_n = 1; frame_in_n = 1;
      tick();
      chk("R3 frame after grant loss", {63'd0, frame_n}, 64'd1);
      tick();
      chk("R3 req kept", {63'd0, req_n}, 64'd0);
      chk("R3 frame still idle", {63'd0, frame_n}, 64'd1);
    end
    for (int b = 0; b < busy; b++) begin
      @(negedge clk); gnt_n = 0; irdy_in_n = b[0]; frame_in_n = ~b[0];
      tick();
      chk("R2 frame while busy", {63'd0, frame_n}, 64'd1);
      chk("R2 frame32 while busy", {63'd0, frame_n32}, 64'd1);
    end
    @(negedge clk); gnt_n = 0; frame_in_n = 1; irdy_in_n = 1;
    tick();
    chk("R4 frame phase1", {63'd0, frame_n}, 64'd0);
    chk("R12 req in phase", {63'd0, req_n}, 64'd1);
    chk("R9 low oe", {62'd0, ad_lo_oe, cbe_lo_oe}, 64'd3);
    chk("R4 ad low", {32'd0, ad_out[31:0]}, {32'd0, addr[31:0]});
    if (dual) begin
      chk("R6 ad high", {32'd0, ad_out[63:32]}, {32'd0, addr[63:32]});
      chk("R6 cbe", {56'd0, cbe_out}, {56'd0, cmd, 4'b1101});
      chk("R6 hi oe", {62'd0, ad_hi_oe, cbe_hi_oe}, 64'd3);
      chk("R11 no early done", {63'd0, addr_done}, 64'd0);
    end else begin
      chk("R5 single cbe", {60'd0, cbe_out[3:0]}, {60'd0, cmd});
      chk("R5 no hi oe", {62'd0, ad_hi_oe, cbe_hi_oe}, 64'd0);
      chk("R11 done single", {63'd0, addr_done}, 64'd1);
    end
    chk("R8 frame32", {63'd0, frame_n32}, 64'd0);
    chk("R8 ad32", {32'd0, ad_out32[31:0]}, {32'd0, addr[31:0]});
    chk("R8 cbe32", {60'd0, cbe_out32[3:0]}, {60'd0, cmd});
    chk("R8 hi oe32", {62'd0, ad_hi_oe32, cbe_hi_oe32}, 64'd0);
    chk("R11 done32", {63'd0, done32}, 64'd1);
    @(negedge clk); gnt_n = 1;
    tick();
    chk("R9 narrow release", {61'd0, frame_n32, ad_lo_oe32, cbe_lo_oe32}, 64'd4);
    if (dual) begin
      chk("R7 frame phase2", {63'd0, frame_n}, 64'd0);
      chk("R7 ad low", {32'd0, ad_out[31:0]}, {32'd0, addr[63:32]});
      chk("R7 cbe low", {60'd0, cbe_out[3:0]}, {60'd0, cmd});
      chk("R7 hi oe off", {62'd0, ad_hi_oe, cbe_hi_oe}, 64'd0);
      chk("R11 done phase2", {63'd0, addr_done}, 64'd1);
      tick();
    end
    idle_state("R9 release");
    chk("R12 req after", {63'd0, req_n}, 64'd1);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    for (int c = 0; c < 150000; c++) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [31:0] hi_pat [4];
    hi_pat[0] = 32'd0; hi_pat[1] = 32'd1; hi_pat[2] = 32'h8000_0000; hi_pat[3] = 32'hA5C3_0F96;
    rst_n = 0; loc_req_n = 0; loc_addr = '1; loc_cmd = 4'hF;
    gnt_n = 0; frame_in_n = 1; irdy_in_n = 1;
    repeat (3) tick();
    chk("R10 req reset", {62'd0, req_n, req_n32}, 64'd3);
    idle_state("R10 reset");
    @(negedge clk); rst_n = 1; loc_req_n = 1; gnt_n = 1;
    tick();
    idle_state("R10 after reset");
    for (int h = 0; h < 4; h++)
      for (int c = 0; c < 16; c++)
        for (int w = 0; w < 3; w++)
          run({hi_pat[h], 32'h1357_0000 ^ {c[15:0], 4'(h), 8'(w), 4'(c)}}, 4'(c),
              w, (c + w) % 3, ((c + h + w) % 4) == 0);
    finish_run();
  end
endmodule